// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between a small CPU core and its data storage. For each access it builds a 12-bit data address, either from a 7-bit direct offset joined to a 5-bit bank register or from the low bits of a 16-bit indirect pointer. It then sends the access to one of four regions. The core register window at the bottom of each bank is the same in all 32 banks. The special function window is banked. General purpose RAM is held in this block for the implemented banks. A 16-byte common window at the top of every bank reaches the same physical bytes whatever the bank. Core and special function registers are not stored here: the block only raises a select strobe and carries their read data back.

When an indirect pointer has its top bit set, the access goes to program memory instead. A read drives the word address out to a synchronous program memory port and returns the low byte of the word that comes back, one cycle later than a data read. A write through such a pointer does nothing.

Requests use a valid/ready handshake. An access is taken on a clock edge where `req_valid` and `req_ready` are both high. The block back-pressures only by dropping `req_ready` for the single wait cycle of a program memory read. Responses carry no back-pressure: `rsp_valid` is high for exactly one cycle with `rsp_rdata`, and the consumer must take the data in that cycle. Only reads produce a response.

Top module: `bank_mem_decoder`

## Requirements
- R1: The data address is {bank, offset}. A direct access takes the bank from `req_bsr` and the offset from `req_ofs`. An indirect data access takes pointer bits 11:7 as the bank and bits 6:0 as the offset.
- R2: Offsets 0x00–0x0B raise `reg_sel_core` with `reg_idx` equal to the offset, in every bank, during the accepting cycle.
- R3: Offsets 0x0C–0x1F raise `reg_sel_sfr` with `reg_bank` and `reg_idx` set to the bank and offset. For both register strobes `reg_we` follows `req_write`, and a read returns the `reg_rdata` value sampled at the accepting edge.
- R4: Offsets 0x20–0x6F in banks below GPR_BANKS (default 2) reach 80 separate bytes of RAM per bank. A write there is read back unchanged, and different banks do not alias.
- R5: Offsets 0x70–0x7F reach 16 common bytes that are the same in every bank, through both direct and indirect accesses.
- R6: Offsets 0x20–0x6F in banks at or above GPR_BANKS are unimplemented. Reads from them return 0, and writes to them change no stored byte.
- R7: An indirect read whose pointer bit 15 is 1 drives `pm_en` with `pm_addr` = pointer bits 14:0 in the accepting cycle. It returns the low byte of `pm_rdata_lo` two cycles after acceptance.
- R8: During a program memory read, `req_ready` is low for exactly the one cycle after acceptance and high again after that.
- R9: An indirect write whose pointer bit 15 is 1 raises no strobe and no `pm_en`, stalls nothing, produces no response and changes no stored byte.
- R10: A data read gives `rsp_valid` exactly one cycle after acceptance. A write gives no response.
- R11: After reset `req_ready` is 1, `rsp_valid` is 0 and all stored RAM bytes read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = use pointer, 0 = bank + offset |
| req_bsr | input | 5 | Bank for direct access |
| req_ofs | input | 7 | Offset for direct access |
| req_ptr | input | 16 | Indirect pointer |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_rdata | output | 8 | Read data |
| reg_sel_core | output | 1 | Core register select strobe |
| reg_sel_sfr | output | 1 | Special function register select strobe |
| reg_we | output | 1 | Write enable for the selected register |
| reg_bank | output | 5 | Bank of the register access |
| reg_idx | output | 7 | Offset of the register access |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, same cycle as the strobe |
| pm_en | output | 1 | Program memory read enable |
| pm_addr | output | 15 | Program memory word address |
| pm_rdata_lo | input | 8 | Low byte of program word, one cycle after `pm_en` |

## Verification
The bench goes after the region edges at 0x0B/0x0C, 0x1F/0x20, 0x6F/0x70 and the last bank with RAM. A decoder that is off by one at any of these would send an access to the wrong strobe or the wrong RAM byte. It writes common bytes through one bank and reads them through another bank and through a pointer, so a decoder that banks the common window would return stale data. It also writes into unimplemented banks and through program-memory pointers, then reads the bytes those writes could alias. A design that folds those addresses onto real RAM would corrupt them. Program memory reads are timed cycle by cycle, so a missing or doubled stall shows up as a wrong `req_ready` or a response in the wrong cycle.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  typedef enum logic [2:0] {
    RG_CORE   = 3'd0,
    RG_SFR    = 3'd1,
    RG_GPR    = 3'd2,
    RG_COMMON = 3'd3,
    RG_NONE   = 3'd4,
    RG_PROG   = 3'd5
  } region_e;
endpackage

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
  import bmd_pkg::*;
#(
  parameter int BANK_W     = 5,
  parameter int OFS_W      = 7,
  parameter int CORE_CNT   = 12,
  parameter int SFR_END    = 32,
  parameter int COMMON_CNT = 16,
  parameter int GPR_BANKS  = 2,
  parameter int GPR_AW     = 8,
  parameter int COM_AW     = 4
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  output region_e           region,
  output logic [GPR_AW-1:0] gpr_idx,
  output logic [COM_AW-1:0] com_idx
);
  localparam int SPAN         = 1 << OFS_W;
  localparam int COM_START    = SPAN - COMMON_CNT;
  localparam int GPR_PER_BANK = COM_START - SFR_END;
  localparam logic [OFS_W-1:0]  CORE_END_L  = OFS_W'(CORE_CNT);
  localparam logic [OFS_W-1:0]  SFR_END_L   = OFS_W'(SFR_END);
  localparam logic [OFS_W-1:0]  COM_START_L = OFS_W'(COM_START);
  localparam logic [BANK_W:0]   BANKS_L     = (BANK_W+1)'(GPR_BANKS);

  logic bank_has_ram;
  assign bank_has_ram = {1'b0, bank} < BANKS_L;

  always_comb begin
    if (ofs < CORE_END_L)         region = RG_CORE;
    else if (ofs < SFR_END_L)     region = RG_SFR;
    else if (ofs >= COM_START_L)  region = RG_COMMON;
    else if (bank_has_ram)        region = RG_GPR;
    else                          region = RG_NONE;
  end

  assign gpr_idx = GPR_AW'(32'(bank) * GPR_PER_BANK + 32'(ofs) - SFR_END);
  assign com_idx = COM_AW'(ofs - COM_START_L);
endmodule

// File: rtl/bmd_byte_store.sv
module bmd_byte_store #(
  parameter int DEPTH = 160,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we && ({1'b0, waddr} < DEPTH_L)) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
    end
  end

  // R4: the decoder must never hand this store an index past its end
  a_r4_waddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ({1'b0, waddr} < DEPTH_L));
endmodule

// File: rtl/bmd_prog_wait.sv
module bmd_prog_wait #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] pm_byte,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] byte_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      byte_q <= '0;
    end else begin
      busy <= start;
      done <= busy;
      if (busy) byte_q <= pm_byte;
    end
  end

  // R8: the wait lasts one cycle only
  a_r8_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R7: the wait cycle is always followed by the response
  a_r7_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);
endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
  import bmd_pkg::*;
#(
  parameter int BANK_W     = 5,
  parameter int OFS_W      = 7,
  parameter int PTR_W      = 16,
  parameter int DW         = 8,
  parameter int CORE_CNT   = 12,
  parameter int SFR_END    = 32,
  parameter int COMMON_CNT = 16,
  parameter int GPR_BANKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_indirect,
  input  logic [BANK_W-1:0] req_bsr,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              reg_sel_core,
  output logic              reg_sel_sfr,
  output logic              reg_we,
  output logic [BANK_W-1:0] reg_bank,
  output logic [OFS_W-1:0]  reg_idx,
  output logic [DW-1:0]     reg_wdata,
  input  logic [DW-1:0]     reg_rdata,
  output logic              pm_en,
  output logic [PTR_W-2:0]  pm_addr,
  input  logic [DW-1:0]     pm_rdata_lo
);
  localparam int PM_BIT       = PTR_W - 1;
  localparam int GPR_PER_BANK = (1 << OFS_W) - COMMON_CNT - SFR_END;
  localparam int GPR_DEPTH    = GPR_BANKS * GPR_PER_BANK;
  localparam int GPR_AW       = $clog2(GPR_DEPTH);
  localparam int COM_AW       = $clog2(COMMON_CNT);

  // ---------------- address formation ----------------
  logic              acc, is_pm;
  logic [BANK_W-1:0] bank;
  logic [OFS_W-1:0]  ofs;
  region_e           region;
  logic [GPR_AW-1:0] gpr_idx;
  logic [COM_AW-1:0] com_idx;
  logic              busy, pm_done;
  logic [DW-1:0]     pm_byte_q;

  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;
  assign is_pm     = req_indirect && req_ptr[PM_BIT];
  assign bank      = req_indirect ? req_ptr[BANK_W+OFS_W-1:OFS_W] : req_bsr;
  assign ofs       = req_indirect ? req_ptr[OFS_W-1:0]            : req_ofs;

  bmd_region_decode #(
    .BANK_W(BANK_W), .OFS_W(OFS_W), .CORE_CNT(CORE_CNT), .SFR_END(SFR_END),
    .COMMON_CNT(COMMON_CNT), .GPR_BANKS(GPR_BANKS), .GPR_AW(GPR_AW), .COM_AW(COM_AW)
  ) u_dec (
    .bank(bank), .ofs(ofs), .region(region), .gpr_idx(gpr_idx), .com_idx(com_idx)
  );

  // ---------------- register strobes ----------------
  logic data_acc;
  assign data_acc     = acc && !is_pm;
  assign reg_sel_core = data_acc && (region == RG_CORE);
  assign reg_sel_sfr  = data_acc && (region == RG_SFR);
  assign reg_we       = (reg_sel_core || reg_sel_sfr) && req_write;
  assign reg_bank     = bank;
  assign reg_idx      = ofs;
  assign reg_wdata    = req_wdata;

  // ---------------- RAM regions ----------------
  logic gpr_we, gpr_re, com_we, com_re;
  logic [DW-1:0] gpr_q, com_q;

  assign gpr_we = data_acc &&  req_write && (region == RG_GPR);
  assign gpr_re = data_acc && !req_write && (region == RG_GPR);
  assign com_we = data_acc &&  req_write && (region == RG_COMMON);
  assign com_re = data_acc && !req_write && (region == RG_COMMON);

  bmd_byte_store #(.DEPTH(GPR_DEPTH), .AW(GPR_AW), .DW(DW)) u_gpr (
    .clk(clk), .rst_n(rst_n), .we(gpr_we), .waddr(gpr_idx), .wdata(req_wdata),
    .re(gpr_re), .raddr(gpr_idx), .rdata(gpr_q)
  );

  bmd_byte_store #(.DEPTH(COMMON_CNT), .AW(COM_AW), .DW(DW)) u_com (
    .clk(clk), .rst_n(rst_n), .we(com_we), .waddr(com_idx), .wdata(req_wdata),
    .re(com_re), .raddr(com_idx), .rdata(com_q)
  );

  // ---------------- program memory path ----------------
  assign pm_en   = acc && is_pm && !req_write;
  assign pm_addr = req_ptr[PTR_W-2:0];

  bmd_prog_wait #(.DW(DW)) u_pw (
    .clk(clk), .rst_n(rst_n), .start(pm_en), .pm_byte(pm_rdata_lo),
    .busy(busy), .done(pm_done), .byte_q(pm_byte_q)
  );

  // ---------------- response ----------------
  logic          rd_q;
  region_e       src_q;
  logic [DW-1:0] ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      src_q <= RG_NONE;
      ext_q <= '0;
    end else begin
      rd_q <= data_acc && !req_write;
      if (acc) src_q <= is_pm ? RG_PROG : region;
      if (reg_sel_core || reg_sel_sfr) ext_q <= reg_rdata;
    end
  end

  assign rsp_valid = rd_q || pm_done;

  always_comb begin
    unique case (src_q)
      RG_CORE, RG_SFR: rsp_rdata = ext_q;
      RG_GPR:          rsp_rdata = gpr_q;
      RG_COMMON:       rsp_rdata = com_q;
      RG_PROG:         rsp_rdata = pm_byte_q;
      default:         rsp_rdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  // R10: data reads answer in the next cycle
  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && !is_pm) |=> rsp_valid);
  // R10: writes never answer
  a_r10_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !rsp_valid);
  // R9: program-memory writes neither stall nor fetch
  a_r9_pm_write_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && is_pm) |-> (!pm_en && !reg_sel_core && !reg_sel_sfr));
  // R7 / R8: fetch stalls once, then answers
  a_r7_pm_answer: assert property (@(posedge clk) disable iff (!rst_n)
    pm_en |=> (!req_ready && !rsp_valid) ##1 (rsp_valid && req_ready));
  // R2 / R3: at most one destination per access
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_sel_core, reg_sel_sfr, pm_en, gpr_we | gpr_re, com_we | com_re}));
endmodule

// File: tb/tb_bank_mem_decoder.sv
module tb_bank_mem_decoder;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, req_indirect;
  logic [4:0] req_bsr;
  logic [6:0] req_ofs;
  logic [15:0] req_ptr;
  logic [7:0] req_wdata;
  logic rsp_valid;
  logic [7:0] rsp_rdata;
  logic reg_sel_core, reg_sel_sfr, reg_we;
  logic [4:0] reg_bank;
  logic [6:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;
  logic pm_en;
  logic [14:0] pm_addr;
  logic [7:0] pm_q;

  int n_tests = 0, n_fail = 0;
  logic [7:0] gm [160];
  logic [7:0] cm [16];

  always #5 clk = ~clk;

  bank_mem_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_indirect(req_indirect), .req_bsr(req_bsr),
    .req_ofs(req_ofs), .req_ptr(req_ptr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .reg_sel_core(reg_sel_core),
    .reg_sel_sfr(reg_sel_sfr), .reg_we(reg_we), .reg_bank(reg_bank),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pm_en(pm_en), .pm_addr(pm_addr), .pm_rdata_lo(pm_q)
  );

  function automatic logic [7:0] reg_val(logic [4:0] b, logic [6:0] o);
    return {b[2:0], o[4:0]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] pm_val(logic [14:0] a);
    return a[7:0] ^ a[14:7] ^ 8'h96;
  endfunction

  assign reg_rdata = reg_val(reg_bank, reg_idx);
  always_ff @(posedge clk) if (pm_en) pm_q <= pm_val(pm_addr);

  // 0 core, 1 sfr, 2 gpr, 3 common, 4 unimplemented
  function automatic int region_of(logic [4:0] b, logic [6:0] o);
    if (o < 7'd12) return 0;
    if (o < 7'd32) return 1;
    if (o >= 7'd112) return 3;
    if (b < 5'd2) return 2;
    return 4;
  endfunction

  function automatic logic [7:0] exp_read(logic [4:0] b, logic [6:0] o);
    case (region_of(b, o))
      0, 1: return reg_val(b, o);
      2: return gm[int'(b) * 80 + int'(o) - 32];
      3: return cm[int'(o) - 112];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(bit ind, logic [15:0] ptr, logic [4:0] bsr, logic [6:0] ofs,
                    bit wr, logic [7:0] wd);
    logic [4:0] b;
    logic [6:0] o;
    bit pm;
    int rg;
    logic [7:0] e;
    b  = ind ? ptr[11:7] : bsr;
    o  = ind ? ptr[6:0]  : ofs;
    pm = ind && ptr[15];
    rg = region_of(b, o);
    @(negedge clk);
    req_valid = 1'b1; req_indirect = ind; req_ptr = ptr; req_bsr = bsr;
    req_ofs = ofs; req_write = wr; req_wdata = wd;
    #1;
    if (pm) begin
      chk(pm_en == !wr, "R7/R9 pm_en", 32'(pm_en), 32'(!wr));
      chk(!reg_sel_core && !reg_sel_sfr, "R9 no strobe on pm", 32'({reg_sel_core, reg_sel_sfr}), 0);
      if (!wr) chk(pm_addr == ptr[14:0], "R7 pm_addr", 32'(pm_addr), 32'(ptr[14:0]));
    end else begin
      chk(reg_sel_core == (rg == 0), "R2 core strobe", 32'(reg_sel_core), 32'(rg == 0));
      chk(reg_sel_sfr == (rg == 1), "R3 sfr strobe", 32'(reg_sel_sfr), 32'(rg == 1));
      if (rg == 0) chk(reg_idx == o, "R2 core idx", 32'(reg_idx), 32'(o));
      if (rg == 1) chk({reg_bank, reg_idx} == {b, o}, "R1 R3 sfr address",
                       32'({reg_bank, reg_idx}), 32'({b, o}));
      if (rg < 2) chk(reg_we == wr, "R3 reg_we", 32'(reg_we), 32'(wr));
    end
    e = exp_read(b, o);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (pm && !wr) begin
      chk(!req_ready && !rsp_valid, "R8 stall cycle", 32'({req_ready, rsp_valid}), 0);
      @(negedge clk);
      chk(rsp_valid && req_ready, "R7 R8 pm response", 32'({rsp_valid, req_ready}), 3);
      chk(rsp_rdata == pm_val(ptr[14:0]), "R7 pm data", 32'(rsp_rdata), 32'(pm_val(ptr[14:0])));
    end else if (wr) begin
      chk(!rsp_valid && req_ready, "R9 R10 write silent", 32'({rsp_valid, req_ready}), 1);
      if (!pm && rg == 2) gm[int'(b) * 80 + int'(o) - 32] = wd;
      if (!pm && rg == 3) cm[int'(o) - 112] = wd;
    end else begin
      chk(rsp_valid, "R10 read latency", 32'(rsp_valid), 1);
      chk(rsp_rdata == e, rg == 4 ? "R6 unimplemented read" :
                          rg == 3 ? "R5 common read" :
                          rg == 2 ? "R4 gpr read" : "R3 register read",
          32'(rsp_rdata), 32'(e));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 160; i++) gm[i] = 8'h00;
    for (int i = 0; i < 16; i++) cm[i] = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_indirect = 1'b0;
    req_bsr = '0; req_ofs = '0; req_ptr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R11 reset state", 32'({req_ready, rsp_valid}), 2);
    op(0, 0, 5'd1, 7'h45, 0, 0);                   // R11: RAM cleared
    // R2 edges and mirroring across banks
    op(0, 0, 5'd0, 7'h00, 0, 0);
    op(0, 0, 5'd31, 7'h0B, 1, 8'h12);
    op(1, 16'h0E85, 0, 0, 0, 0);                   // R1: bank 29 offset 5 via pointer
    // R3 edges
    op(0, 0, 5'd9, 7'h0C, 0, 0);
    op(0, 0, 5'd3, 7'h1F, 1, 8'h44);
    // R4 banked RAM edges, no aliasing
    op(0, 0, 5'd0, 7'h20, 1, 8'h11);
    op(0, 0, 5'd1, 7'h20, 1, 8'h22);
    op(0, 0, 5'd1, 7'h6F, 1, 8'h33);
    op(0, 0, 5'd0, 7'h20, 0, 0);
    op(0, 0, 5'd1, 7'h20, 0, 0);
    op(1, 16'h00EF, 0, 0, 0, 0);                   // R1 R4: bank 1 offset 0x6F
    // R5 common window shared
    op(0, 0, 5'd3, 7'h75, 1, 8'h5A);
    op(0, 0, 5'd17, 7'h75, 0, 0);
    op(1, 16'h0F75, 0, 0, 0, 0);
    op(0, 0, 5'd0, 7'h70, 1, 8'hC3);
    op(0, 0, 5'd31, 7'h70, 0, 0);
    // R6 unimplemented bank: read 0, write ignored
    op(0, 0, 5'd2, 7'h20, 1, 8'h77);
    op(0, 0, 5'd2, 7'h20, 0, 0);
    op(0, 0, 5'd0, 7'h20, 0, 0);
    op(0, 0, 5'd1, 7'h20, 0, 0);
    // R7 R8 program memory reads, back to back
    op(1, 16'h8000, 0, 0, 0, 0);
    op(1, 16'hFFFF, 0, 0, 0, 0);
    op(1, 16'h8123, 0, 0, 0, 0);
    // R9 program memory writes ignored
    op(1, 16'h8020, 0, 0, 1, 8'hEE);
    op(1, 16'h80F5, 0, 0, 1, 8'hEE);
    op(0, 0, 5'd0, 7'h20, 0, 0);
    op(0, 0, 5'd1, 7'h75, 0, 0);
    // random mix against the bench model
    for (int i = 0; i < 600; i++) begin
      logic [15:0] p;
      logic [4:0] b;
      bit ind;
      p   = 16'($urandom());
      b   = ($urandom_range(0, 3) == 0) ? 5'($urandom()) : 5'($urandom_range(0, 2));
      ind = $urandom_range(0, 1) == 1;
      if (ind && $urandom_range(0, 3) != 0) p[15:12] = 4'h0;
      if (ind && p[15] == 1'b0) p[11:7] = b;
      op(ind, p, b, 7'($urandom()), $urandom_range(0, 1) == 1, 8'($urandom()));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule